// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Reader

This block moves data from a word-addressed single-port memory onto a 32-bit valid/ready stream port (AXI4-Stream manager: TVALID, TREADY, TDATA, TLAST). Software first builds a linked chain of descriptors in memory. It then pulses `start_i` with the address of the first descriptor. From that point the engine works alone. For each descriptor it reads the three control words, streams the buffer the descriptor points at, and writes a status word back into the descriptor. When the chain ends, it raises `done_o`.

Packets are made of one or more descriptors. The stream marks the last word of a packet with TLAST. The engine looks ahead within a packet. While the next descriptor's buffer starts at the word right after the current burst, and the next descriptor does not open a new packet, the engine folds it into the same burst. A merged burst holds at most `MERGE_MAX` descriptors, and its words leave back to back. Every merged descriptor still receives its own status word once the whole burst has been accepted downstream.

Top module: `sgdma_reader`

## Requirements
- R1: A descriptor occupies four consecutive words at a word address P. P+0 holds the next-descriptor pointer, P+1 holds the buffer start address, P+2 is the control word and P+3 is the status word. In the control word, bits [15:0] give the length in words, bit 30 marks start of packet and bit 31 marks end of packet. Only the low `AW` bits of pointers and addresses are used.
- R2: Buffer words appear on the stream in ascending address order, and descriptors are served in chain order. No word is dropped, repeated or added.
- R3: `m_tlast_o` is high exactly on the final word of a descriptor whose end-of-packet bit is set, and on no other beat.
- R4: While `m_tvalid_o` is high and `m_tready_i` is low, the next cycle still shows the same valid beat with unchanged data and last flag.
- R5: A descriptor whose buffer begins at the word after the current burst's end is merged into that burst. This applies when the current descriptor lacks end-of-packet, the next lacks start-of-packet and is non-empty, and the burst holds fewer than `MERGE_MAX` descriptors. With `m_tready_i` held high, the words of a merged burst leave on consecutive cycles.
- R6: Merging never crosses an end-of-packet, a start-of-packet, a non-adjacent buffer or the `MERGE_MAX` limit. At such a boundary the stream shows at least one idle cycle.
- R7: After all words of a burst have been accepted, each descriptor in the burst receives status 0x8000_0000 OR its length (bit 31 complete, bits [15:0] words moved). No status write happens while a beat is pending on the stream.
- R8: A next pointer of zero ends the chain. `done_o` then rises, the engine returns to idle with the memory port and the stream quiet, and `done_o` clears on the next start.
- R9: A descriptor with length zero receives status 0x4000_0000 (bit 30 error, count zero). The engine then raises `done_o` and stops. Later descriptors are neither streamed nor written.
- R10: During reset, `m_tvalid_o`, `done_o` and `mem_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that begins walking the chain |
| head_i | input | AW | Word address of the first descriptor |
| done_o | output | 1 | Set at chain end or error stop, cleared by start |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write (status write-back) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Status word written back |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | 32 | Stream data word |
| m_tlast_o | output | 1 | Final word of a packet |

## Verification
The bench targets several boundaries. It runs a packet split over three adjacent buffers, where a design that fails to merge would insert fetch gaps between them. It places a contiguous buffer at the start of a new packet, where a design that merges across packets would lose the idle gap and could misplace TLAST. A run of six adjacent descriptors exercises the merge limit: a counter that overflows would corrupt status slots or skip the refetch. A pseudo-random ready pattern catches a design that advances its read address while stalled, which would skip or duplicate words. A zero-length descriptor in mid-chain must leave earlier statuses complete, stop the walk and leave the following descriptor untouched.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int WORD_W      = 32;
  localparam int LEN_W       = 16;
  localparam int CTL_EOP_BIT = 31;
  localparam int CTL_SOP_BIT = 30;
  localparam int ST_CPL_BIT  = 31;
  localparam int ST_ERR_BIT  = 30;

  typedef enum logic [2:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_STRM, S_WB
  } sg_state_e;
endpackage

// File: rtl/sgdma_obuf.sv
module sgdma_obuf
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] pdata_i,
  input  logic              plast_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              last_o,
  output logic [1:0]        cnt_o
);
  logic [WORD_W-1:0] slot_d [2];
  logic              slot_l [2];
  logic              wr_q, rd_q, wr_n, rd_n;
  logic [1:0]        cnt_q, cnt_n;

  always_comb begin
    wr_n  = wr_q ^ push_i;
    rd_n  = rd_q ^ pop_i;
    cnt_n = cnt_q + 2'(push_i) - 2'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      slot_d[wr_q] <= pdata_i;
      slot_l[wr_q] <= plast_i;
    end
  end

  assign valid_o = (cnt_q != 2'd0);
  assign data_o  = slot_d[rd_q];
  assign last_o  = valid_o & slot_l[rd_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int AW        = 10,
  parameter int MERGE_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     head_i,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [1:0]        ob_cnt_i,
  input  logic              ob_pop_i,
  output logic              push_o,
  output logic              push_last_o
);
  localparam int CW = $clog2(MERGE_MAX + 1);
  localparam int IW = (MERGE_MAX > 1) ? $clog2(MERGE_MAX) : 1;
  localparam int RW = LEN_W + CW;

  sg_state_e       st_q, st_n;
  logic [AW-1:0]   ptr_q, ptr_n, fnx_q, fnx_n, fbuf_q, fbuf_n;
  logic [AW-1:0]   chain_q, chain_n, baddr_q, baddr_n, bend_q, bend_n;
  logic [RW-1:0]   rem_q, rem_n;
  logic [CW-1:0]   ecnt_q, ecnt_n;
  logic [IW-1:0]   wbi_q, wbi_n, ent_idx;
  logic            look_q, look_n, eop_q, eop_n, err_q, err_n;
  logic            pend_q, pend_n, plast_q, plast_n, done_q, done_n;
  logic            ent_we, issue, space;
  logic [2:0]      occ;
  logic [AW-1:0]   ent_ptr [MERGE_MAX];
  logic [LEN_W-1:0] ent_len [MERGE_MAX];
  logic [LEN_W-1:0] d_len;
  logic            d_eop, d_sop, unused_rdata;

  assign d_len        = mem_rdata_i[LEN_W-1:0];
  assign d_eop        = mem_rdata_i[CTL_EOP_BIT];
  assign d_sop        = mem_rdata_i[CTL_SOP_BIT];
  assign unused_rdata = ^mem_rdata_i;
  assign occ          = 3'(ob_cnt_i) + 3'(pend_q);
  assign space        = (occ <= (3'd1 + 3'(ob_pop_i)));

  always_comb begin
    st_n = st_q;   ptr_n = ptr_q;   fnx_n = fnx_q;   fbuf_n = fbuf_q;
    chain_n = chain_q; baddr_n = baddr_q; bend_n = bend_q; rem_n = rem_q;
    ecnt_n = ecnt_q; wbi_n = wbi_q; look_n = look_q; eop_n = eop_q;
    err_n = err_q; plast_n = plast_q; done_n = done_q;
    mem_en_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = ptr_q; mem_wdata_o = '0;
    ent_we = 1'b0; ent_idx = IW'(ecnt_q); issue = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        ptr_n = head_i; done_n = 1'b0; err_n = 1'b0; look_n = 1'b0; st_n = S_F0;
      end
      S_F0: begin mem_en_o = 1'b1; mem_addr_o = ptr_q; st_n = S_F1; end
      S_F1: begin
        mem_en_o = 1'b1; mem_addr_o = ptr_q + AW'(1);
        fnx_n = mem_rdata_i[AW-1:0]; st_n = S_F2;
      end
      S_F2: begin
        mem_en_o = 1'b1; mem_addr_o = ptr_q + AW'(2);
        fbuf_n = mem_rdata_i[AW-1:0]; st_n = S_F3;
      end
      S_F3: begin
        if (!look_q) begin
          ent_we = 1'b1; ent_idx = '0; ecnt_n = CW'(1); chain_n = fnx_q;
          baddr_n = fbuf_q; bend_n = fbuf_q + AW'(d_len);
          rem_n = RW'(d_len); eop_n = d_eop;
          if (d_len == '0) begin
            err_n = 1'b1; wbi_n = '0; st_n = S_WB;
          end else if (!d_eop && fnx_q != '0 && MERGE_MAX > 1) begin
            look_n = 1'b1; ptr_n = fnx_q; st_n = S_F0;
          end else begin
            st_n = S_STRM;
          end
        end else if (fbuf_q == bend_q && d_len != '0 && !d_sop) begin
          ent_we = 1'b1; ecnt_n = ecnt_q + CW'(1); chain_n = fnx_q;
          bend_n = bend_q + AW'(d_len); rem_n = rem_q + RW'(d_len); eop_n = d_eop;
          if (!d_eop && fnx_q != '0 && (ecnt_q + CW'(1)) < CW'(MERGE_MAX)) begin
            ptr_n = fnx_q; st_n = S_F0;
          end else begin
            look_n = 1'b0; st_n = S_STRM;
          end
        end else begin
          look_n = 1'b0; st_n = S_STRM;
        end
      end
      S_STRM: begin
        if (rem_q != '0 && space) begin
          issue = 1'b1; mem_en_o = 1'b1; mem_addr_o = baddr_q;
          baddr_n = baddr_q + AW'(1); rem_n = rem_q - RW'(1);
          plast_n = eop_q && (rem_q == RW'(1));
        end else if (rem_q == '0 && !pend_q && ob_cnt_i == 2'd0) begin
          wbi_n = '0; st_n = S_WB;
        end
      end
      S_WB: begin
        mem_en_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = ent_ptr[wbi_q] + AW'(3);
        if (err_q) mem_wdata_o[ST_ERR_BIT] = 1'b1;
        else begin
          mem_wdata_o[ST_CPL_BIT]  = 1'b1;
          mem_wdata_o[LEN_W-1:0]   = ent_len[wbi_q];
        end
        wbi_n = wbi_q + IW'(1);
        if ((CW'(wbi_q) + CW'(1)) == ecnt_q) begin
          if (err_q || chain_q == '0) begin
            done_n = 1'b1; st_n = S_IDLE;
          end else begin
            ptr_n = chain_q; st_n = S_F0;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
    pend_n = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ptr_q <= '0; fnx_q <= '0; fbuf_q <= '0; chain_q <= '0;
      baddr_q <= '0; bend_q <= '0; rem_q <= '0; ecnt_q <= '0; wbi_q <= '0;
      look_q <= 1'b0; eop_q <= 1'b0; err_q <= 1'b0; pend_q <= 1'b0;
      plast_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_n; ptr_q <= ptr_n; fnx_q <= fnx_n; fbuf_q <= fbuf_n;
      chain_q <= chain_n; baddr_q <= baddr_n; bend_q <= bend_n; rem_q <= rem_n;
      ecnt_q <= ecnt_n; wbi_q <= wbi_n; look_q <= look_n; eop_q <= eop_n;
      err_q <= err_n; pend_q <= pend_n; plast_q <= plast_n; done_q <= done_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_we) begin
      ent_ptr[ent_idx] <= ptr_q;
      ent_len[ent_idx] <= d_len;
    end
  end

  assign push_o      = pend_q;
  assign push_last_o = plast_q;
  assign done_o      = done_q;
endmodule

// File: rtl/sgdma_reader.sv
module sgdma_reader
  import sgdma_pkg::*;
#(
  parameter int AW        = 10,
  parameter int MERGE_MAX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] head_i,
  output logic          done_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          m_tvalid_o,
  input  logic          m_tready_i,
  output logic [31:0]   m_tdata_o,
  output logic          m_tlast_o
);
  logic       rst_q1, rst_s;
  logic       pop, push, push_last;
  logic [1:0] ob_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_s  <= rst_q1;
    end
  end

  assign pop = m_tvalid_o & m_tready_i;

  sgdma_ctrl #(.AW(AW), .MERGE_MAX(MERGE_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start_i(start_i), .head_i(head_i),
    .done_o(done_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .ob_cnt_i(ob_cnt), .ob_pop_i(pop),
    .push_o(push), .push_last_o(push_last)
  );

  sgdma_obuf u_obuf (
    .clk(clk), .rst_n(rst_s), .push_i(push), .pdata_i(mem_rdata_i),
    .plast_i(push_last), .pop_i(pop), .valid_o(m_tvalid_o),
    .data_o(m_tdata_o), .last_o(m_tlast_o), .cnt_o(ob_cnt)
  );
endmodule

// File: rtl/sgdma_reader_chk.sv
module sgdma_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic        mem_en_o,
  input logic        mem_we_o,
  input logic [31:0] mem_wdata_o,
  input logic        m_tvalid_o,
  input logic        m_tready_i,
  input logic [31:0] m_tdata_o,
  input logic        m_tlast_o
);
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));

  a_r7_wb_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !m_tvalid_o);

  a_r7_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($countones(mem_wdata_o[31:30]) == 1));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_en_o && !m_tvalid_o));

  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_wdata_o[30]) |=> done_o);
endmodule

bind sgdma_reader sgdma_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .mem_en_o(mem_en_o),
  .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .m_tvalid_o(m_tvalid_o),
  .m_tready_i(m_tready_i), .m_tdata_o(m_tdata_o), .m_tlast_o(m_tlast_o)
);

// File: tb/sim_sgdma_reader.sv
module sim_sgdma_reader;
  localparam int AW  = 10;
  localparam int MM  = 4;
  localparam int MSK = (1 << AW) - 1;

  logic          clk, rst_n, start, done, mem_en, mem_we, tvalid, tready, tlast;
  logic [AW-1:0] head, mem_addr;
  logic [31:0]   mem_wdata, mem_rdata, tdata;
  logic          tb_we;
  logic [AW-1:0] tb_a;
  logic [31:0]   tb_d;
  logic [31:0]   mem [0:(1<<AW)-1];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sgdma_reader #(.AW(AW), .MERGE_MAX(MM)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .head_i(head), .done_o(done),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .m_tvalid_o(tvalid),
    .m_tready_i(tready), .m_tdata_o(tdata), .m_tlast_o(tlast)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed { logic [31:0] d; logic l; logic link; } beat_t;
  beat_t       q[$];
  int          sp[$];
  logic [31:0] sv[$];
  int          mode = 0;
  int          cyc = 0;
  int          last_k = 0;
  bit          seen = 0;
  bit          mon = 0;
  bit          p_stall = 0;
  logic [31:0] p_d = '0;
  logic        p_l = 1'b0;
  logic [15:0] lf = 16'hACE1;

  // per-clock reference comparison, sampled between edges
  always @(negedge clk) begin
    beat_t b;
    cyc = cyc + 1;
    if (mode == 1) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tready = lf[0] | lf[2];
    end else tready = 1'b1;
    if (mon) begin
      if (p_stall) chk(tvalid && tdata == p_d && tlast == p_l, "R4 held beat", tdata, p_d);
      if (tvalid && tready) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected beat", tdata, 32'h0);
        else begin
          b = q.pop_front();
          chk(tdata == b.d, "R2 data", tdata, b.d);
          chk(tlast == b.l, "R3 last", 32'(tlast), 32'(b.l));
          if (seen && b.link && mode == 0) chk(cyc == last_k + 1, "R5 gapless", cyc, last_k + 1);
          if (seen && !b.link) chk(cyc > last_k + 1, "R6 boundary gap", cyc, last_k + 2);
          last_k = cyc;
          seen = 1;
        end
      end
      p_stall = tvalid && !tready;
      p_d = tdata;
      p_l = tlast;
    end
  end

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_a = AW'(a); tb_d = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input int a, input int nx, input int bf, input int len,
                          input bit sop, input bit eop, input logic [7:0] tag);
    wr(a, 32'(nx));
    wr(a + 1, 32'(bf));
    wr(a + 2, {eop, sop, 14'h0, 16'(len)});
    wr(a + 3, 32'h0);
    for (int i = 0; i < len; i++) wr(bf + i, {tag, 8'h5A, 16'(bf + i)});
  endtask

  // expected beats and statuses from the descriptor rules
  task automatic model(input int hd);
    int p, nx, bf, len, cnt, pend;
    bit in_g, peop, lnk;
    logic [31:0] c;
    p = hd; cnt = 0; pend = 0; in_g = 0; peop = 1;
    while (1) begin
      nx  = int'(mem[p][AW-1:0]);
      bf  = int'(mem[p + 1][AW-1:0]);
      c   = mem[p + 2];
      len = int'(c[15:0]);
      if (len == 0) begin
        sp.push_back(p + 3); sv.push_back(32'h4000_0000);
        break;
      end
      lnk = in_g && !peop && !c[30] && bf == pend && cnt < MM;
      cnt = lnk ? cnt + 1 : 1;
      for (int w = 0; w < len; w++)
        q.push_back('{mem[bf + w], c[31] && w == len - 1, (w > 0) || lnk});
      sp.push_back(p + 3); sv.push_back(32'h8000_0000 | 32'(len));
      pend = (bf + len) & MSK;
      peop = c[31];
      in_g = 1;
      p = nx;
      if (p == 0) break;
    end
  endtask

  task automatic run(input int hd, input int md);
    int p;
    logic [31:0] v;
    model(hd);
    mode = md;
    seen = 0;
    @(negedge clk);
    start = 1'b1; head = AW'(hd);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R8 done cleared by start", 32'(done), 32'h0);
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    chk(done, "R8 done at chain end", 32'(done), 32'h1);
    chk(!mem_en && !tvalid, "R8 quiet when done", 32'(mem_en), 32'h0);
    chk(q.size() == 0, "R2 all beats seen", 32'(q.size()), 32'h0);
    q.delete();
    while (sp.size() > 0) begin
      p = sp.pop_front();
      v = sv.pop_front();
      if (v[30]) chk(mem[p] == v, "R9 error status", mem[p], v);
      else       chk(mem[p] == v, "R7 status", mem[p], v);
    end
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_none
    wait (wd);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; head = '0; tb_we = 1'b0; tb_a = '0; tb_d = '0;
    repeat (3) @(negedge clk);
    chk(!tvalid, "R10 reset tvalid", 32'(tvalid), 32'h0);
    chk(!done, "R10 reset done", 32'(done), 32'h0);
    chk(!mem_en, "R10 reset mem_en", 32'(mem_en), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon = 1;

    // R1 R2 R3 R7: one descriptor packet
    put_desc(16'h010, 0, 16'h100, 4, 1, 1, 8'h11);
    run(16'h010, 0);

    // R5 R6: merged packet, adjacent new packet, non-adjacent pair
    put_desc(16'h020, 16'h030, 16'h140, 2, 1, 0, 8'h22);
    put_desc(16'h030, 16'h040, 16'h142, 3, 0, 0, 8'h22);
    put_desc(16'h040, 16'h050, 16'h145, 1, 0, 1, 8'h22);
    put_desc(16'h050, 16'h060, 16'h146, 2, 1, 1, 8'h22);
    put_desc(16'h060, 16'h070, 16'h160, 2, 1, 0, 8'h22);
    put_desc(16'h070, 0, 16'h170, 1, 0, 1, 8'h22);
    run(16'h020, 0);

    // R4: same chain with fresh data under backpressure
    put_desc(16'h020, 16'h030, 16'h140, 2, 1, 0, 8'h33);
    put_desc(16'h030, 16'h040, 16'h142, 3, 0, 0, 8'h33);
    put_desc(16'h040, 16'h050, 16'h145, 1, 0, 1, 8'h33);
    put_desc(16'h050, 16'h060, 16'h146, 2, 1, 1, 8'h33);
    put_desc(16'h060, 16'h070, 16'h160, 2, 1, 0, 8'h33);
    put_desc(16'h070, 0, 16'h170, 1, 0, 1, 8'h33);
    run(16'h020, 1);

    // R5 R6: six adjacent descriptors exceed the merge limit
    put_desc(16'h080, 16'h090, 16'h200, 1, 1, 0, 8'h44);
    put_desc(16'h090, 16'h0A0, 16'h201, 2, 0, 0, 8'h44);
    put_desc(16'h0A0, 16'h0B0, 16'h203, 1, 0, 0, 8'h44);
    put_desc(16'h0B0, 16'h0C0, 16'h204, 3, 0, 0, 8'h44);
    put_desc(16'h0C0, 16'h0D0, 16'h207, 2, 0, 0, 8'h44);
    put_desc(16'h0D0, 0, 16'h209, 1, 0, 1, 8'h44);
    run(16'h080, 0);

    // R9: zero-length descriptor stops the walk
    put_desc(16'h300, 16'h310, 16'h380, 2, 1, 0, 8'h55);
    put_desc(16'h310, 16'h320, 16'h388, 0, 0, 0, 8'h55);
    put_desc(16'h320, 0, 16'h390, 2, 0, 1, 8'h55);
    run(16'h300, 0);
    chk(mem[16'h323] == 32'h0, "R9 later descriptor untouched", mem[16'h323], 32'h0);

    // R1 R4: single descriptor again under backpressure
    put_desc(16'h010, 0, 16'h100, 5, 1, 1, 8'h66);
    run(16'h010, 1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule